// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a shared two-port memory and decides, once per clock, what happens when both ports aim at the same word. Each port presents an enable, an address and a write request. When both ports are enabled at equal addresses, the port that settled on that word first keeps access. The other port gets an active-low busy flag, and its write qualifier is withheld. The write qualifier is the signal the memory uses to accept a write.

A strap selects the role of the device. A master computes busy itself. A slave takes busy from an external master and passes it through, so that several memories placed side by side for a wider word all obey one arbitration outcome. The write qualifiers always follow the effective busy. On a slave, a port that its master marks busy therefore cannot start a write.

Arrival order is judged against the previous clock. A port whose enable was already high at the same address in the previous cycle counts as earlier. A port that only now enabled, or only now moved to the address, counts as later. The block holds ownership in a register for as long as the match continues at the same word.

Top module: `dp_clash_arbiter`

## Requirements
- R1: In master mode (`masterMode`=1) a busy output is low only while both enables are high and `leftAddr` equals `rightAddr`; otherwise both `leftBusyN` and `rightBusyN` are high.
- R2: A port counts as earlier if, in the previous cycle, its enable was high at the same address it presents now. When exactly one port is earlier at a match, the other port's busy goes low in the same cycle, and the earlier port's busy stays high.
- R3: When neither port is earlier at a new match (both arrive in the same cycle), the left port wins and only `rightBusyN` goes low.
- R4: In master mode, at most one busy output is low at any time, and exactly one is low while a match exists.
- R5: While a match continues at the same word, the owner does not change. A match that reappears, or that moves to a different word, is arbitrated afresh by R2 and R3.
- R6: Busy returns high in the same cycle that the addresses differ or either enable drops.
- R7: With `masterMode`=0, `leftBusyN` equals `leftBusyInN` and `rightBusyN` equals `rightBusyInN`, and the block's own arbitration has no effect on them.
- R8: `leftWrOk` = `leftEn` & `leftWrite` & `leftBusyN`, and the same holds on the right side. So a port with busy low (computed or received) never gets a write qualifier.
- R9: While `rstN` is low in master mode, both busy outputs are high, and ownership is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1: busy computed here; 0: busy received |
| leftEn | input | 1 | Left port enable, active high |
| leftAddr | input | ADDR_W | Left port word address |
| leftWrite | input | 1 | Left port write request |
| rightEn | input | 1 | Right port enable, active high |
| rightAddr | input | ADDR_W | Right port word address |
| rightWrite | input | 1 | Right port write request |
| leftBusyInN | input | 1 | Busy from a master for the left port (slave mode) |
| rightBusyInN | input | 1 | Busy from a master for the right port (slave mode) |
| leftBusyN | output | 1 | Effective busy to the left port, active low |
| rightBusyN | output | 1 | Effective busy to the right port, active low |
| leftWrOk | output | 1 | Left write qualifier |
| rightWrOk | output | 1 | Right write qualifier |

## Verification
The bench builds the block with `ADDR_W`=12, the smallest width allowed, and draws addresses from a set that includes both ends of the range and its midpoint. It sweeps every enable pair against every address pair, for each arrival order: simultaneous, right first and left first. This covers the tie rule, the earlier-port rule, holding ownership and release for all combinations of equal and unequal addresses. Directed sequences then cover moving the match to a new word, slave pass-through with every busy-input pattern, and behaviour during reset.

// File: rtl/dp_clash_pkg.sv
package dp_clash_pkg;
  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_e;

  // datapath -> control: what the comparators see this cycle
  typedef struct packed {
    logic match;
    logic leftSteady;
    logic rightSteady;
    logic heldSame;
  } pathStatus_t;

  // control -> datapath: arbitration strobes
  typedef struct packed {
    logic blockLeft;
    logic blockRight;
    logic captureAddr;
  } ctrlStrobe_t;
endpackage

// File: rtl/dp_clash_path.sv
module dp_clash_path
  import dp_clash_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrite,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrite,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  input  ctrlStrobe_t       strobe,
  output pathStatus_t       status,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWrOk,
  output logic              rightWrOk
);
  localparam int NUM_PORTS = 2;
  localparam int LEFT_IDX  = 0;
  localparam int RIGHT_IDX = 1;

  logic [NUM_PORTS-1:0] enVec;
  logic [ADDR_W-1:0]    addrVec [NUM_PORTS];
  logic [NUM_PORTS-1:0] steadyVec;
  logic [ADDR_W-1:0]    heldAddr;

  assign enVec[LEFT_IDX]    = leftEn;
  assign enVec[RIGHT_IDX]   = rightEn;
  assign addrVec[LEFT_IDX]  = leftAddr;
  assign addrVec[RIGHT_IDX] = rightAddr;

  // per-port history: was this port already parked on this word last cycle
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hist
    logic              prevEn;
    logic [ADDR_W-1:0] prevAddr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevEn   <= 1'b0;
        prevAddr <= '0;
      end else begin
        prevEn   <= enVec[p];
        prevAddr <= addrVec[p];
      end
    end
    assign steadyVec[p] = prevEn && (prevAddr == addrVec[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   heldAddr <= '0;
    else if (strobe.captureAddr) heldAddr <= leftAddr;
  end

  assign status.match       = leftEn && rightEn && (leftAddr == rightAddr);
  assign status.leftSteady  = steadyVec[LEFT_IDX];
  assign status.rightSteady = steadyVec[RIGHT_IDX];
  assign status.heldSame    = (leftAddr == heldAddr);

  assign leftBusyN  = masterMode ? ~strobe.blockLeft  : leftBusyInN;
  assign rightBusyN = masterMode ? ~strobe.blockRight : rightBusyInN;
  assign leftWrOk   = leftEn  && leftWrite  && leftBusyN;
  assign rightWrOk  = rightEn && rightWrite && rightBusyN;

  // R1: computed busy only during a real match
  assert_busy_needs_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && (!leftBusyN || !rightBusyN) |-> leftEn && rightEn && (leftAddr == rightAddr));

  // R4: never both busy, exactly one during contention
  assert_one_loser_R4: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |-> ($countones({~leftBusyN, ~rightBusyN}) == (status.match ? 1 : 0)));

  // R5: ownership holds while the match stays on the same word
  assert_owner_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && $past(masterMode) && $past(rstN) && status.match && $past(status.match)
      && (leftAddr == $past(leftAddr))
      |-> (leftBusyN == $past(leftBusyN)) && (rightBusyN == $past(rightBusyN)));

  // R8: a busy port is never granted a write
  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!leftBusyN |-> !leftWrOk) and (!rightBusyN |-> !rightWrOk));

  // R9: reset keeps busy released in master mode
  always @(posedge clk) begin
    if (rstN === 1'b0 && masterMode === 1'b1)
      assert_reset_idle_R9: assert (leftBusyN && rightBusyN);
  end
endmodule

// File: rtl/dp_clash_ctrl.sv
module dp_clash_ctrl
  import dp_clash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pathStatus_t status,
  output ctrlStrobe_t strobe
);
  owner_e ownerQ, ownerNow;

  always_comb begin
    if (!rstN || !status.match) begin
      ownerNow = OWN_NONE;
    end else if (ownerQ != OWN_NONE && status.heldSame) begin
      ownerNow = ownerQ;                       // match continues on the same word
    end else if (status.rightSteady && !status.leftSteady) begin
      ownerNow = OWN_RIGHT;                    // right was parked there first
    end else begin
      ownerNow = OWN_LEFT;                     // left first, or tie goes left
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ownerQ <= OWN_NONE;
    else       ownerQ <= ownerNow;
  end

  assign strobe.blockLeft   = (ownerNow == OWN_RIGHT);
  assign strobe.blockRight  = (ownerNow == OWN_LEFT);
  assign strobe.captureAddr = status.match;

  // R3: a fresh match with no earlier port always grants the left side
  assert_tie_left_R3: assert property (@(posedge clk) disable iff (!rstN)
    status.match && !status.leftSteady && !status.rightSteady |-> strobe.blockRight && !strobe.blockLeft);
endmodule

// File: rtl/dp_clash_arbiter.sv
module dp_clash_arbiter
  import dp_clash_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrite,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrite,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWrOk,
  output logic              rightWrOk
);
  pathStatus_t status;
  ctrlStrobe_t strobe;

  dp_clash_path #(.ADDR_W(ADDR_W)) path_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWrite(leftWrite),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWrite(rightWrite),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .strobe(strobe), .status(status),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWrOk(leftWrOk), .rightWrOk(rightWrOk)
  );

  dp_clash_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe)
  );
endmodule

// File: tb/dp_clash_arbiter_tb_top.sv
`timescale 1ns/100ps
module dp_clash_arbiter_tb_top;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic leftEn = 1'b0, rightEn = 1'b0, leftWrite = 1'b1, rightWrite = 1'b1;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyN, rightBusyN, leftWrOk, rightWrOk;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  dp_clash_arbiter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWrite(leftWrite),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWrite(rightWrite),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWrOk(leftWrOk), .rightWrOk(rightWrOk)
  );

  function automatic logic [AW-1:0] pick(input int i);
    case (i)
      0: return 12'h000;
      1: return 12'h001;
      2: return 12'h800;
      default: return 12'hFFF;
    endcase
  endfunction

  // drive after the falling edge, settle before the next rising edge
  task automatic drive(input logic le, input logic [AW-1:0] la, input logic re, input logic [AW-1:0] ra);
    @(negedge clk);
    leftEn = le; leftAddr = la; rightEn = re; rightAddr = ra;
    #1;
  endtask

  task automatic checkBusy(input string req, input logic expL, input logic expR);
    checks++;
    if (leftBusyN !== expL || rightBusyN !== expR) begin
      errors++;
      $display("FAIL %s busy L/R got %b%b expected %b%b (la=%h ra=%h)", req,
               leftBusyN, rightBusyN, expL, expR, leftAddr, rightAddr);
    end
  endtask

  task automatic checkWr(input string req, input logic expL, input logic expR);
    checks++;
    if (leftWrOk !== expL || rightWrOk !== expR) begin
      errors++;
      $display("FAIL %s wrOk L/R got %b%b expected %b%b", req, leftWrOk, rightWrOk, expL, expR);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: contention presented while held in reset
    drive(1, 12'h123, 1, 12'h123);
    checkBusy("R9", 1, 1);
    @(negedge clk); rstN = 1'b1;
    drive(0, 0, 0, 0);

    // R1 R3 R8: simultaneous arrival, every enable and address pair
    for (int le = 0; le < 2; le++)
      for (int re = 0; re < 2; re++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            logic m;
            m = le[0] && re[0] && (a == b);
            drive(0, 0, 0, 0);
            drive(le[0], pick(a), re[0], pick(b));
            checkBusy(m ? "R3" : "R1", 1'b1, ~m);
            checkWr("R8", le[0], re[0] & ~m);
          end

    // R2 R5 R6: right parked first, left arrives
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        logic m;
        m = (a == b);
        drive(0, 0, 0, 0);
        drive(0, pick(a), 1, pick(b));
        checkBusy("R1", 1, 1);
        drive(1, pick(a), 1, pick(b));
        checkBusy("R2", ~m, 1'b1);
        checkWr("R8", ~m, 1'b1);
        drive(1, pick(a), 1, pick(b));
        checkBusy("R5", ~m, 1'b1);
        drive(1, pick(a), 0, pick(b));
        checkBusy("R6", 1, 1);
      end

    // R2: left parked first, right arrives
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        drive(0, 0, 0, 0);
        drive(1, pick(a), 0, pick(b));
        drive(1, pick(a), 1, pick(b));
        checkBusy("R2", 1'b1, ~(a == b));
      end

    // R5: match moves to a new word together -> fresh tie -> left wins
    drive(0, 0, 0, 0);
    drive(0, 12'h010, 1, 12'h010);
    drive(1, 12'h010, 1, 12'h010);
    checkBusy("R2", 0, 1);
    drive(1, 12'h020, 1, 12'h020);
    checkBusy("R5", 1, 0);
    // R6: right leaves by address, left released same cycle
    drive(1, 12'h020, 1, 12'h021);
    checkBusy("R6", 1, 1);
    // R5: right returns to the word the left holds -> left earlier
    drive(1, 12'h020, 1, 12'h020);
    checkBusy("R5", 1, 0);

    // R7: slave mode follows busy inputs, own arbitration ignored
    masterMode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      leftBusyInN = k[0]; rightBusyInN = k[1];
      drive(1, 12'h0F0, 1, 12'h0F0);
      checkBusy("R7", k[0], k[1]);
      checkWr("R8", k[0], k[1]);
    end
    drive(0, 0, 0, 0);
    checkWr("R8", 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule